// File: doc/BRIEF.md
# Byte-Wide Configuration Loader

This block sits on the host side of a byte-wide peripheral configuration port. It takes a configuration file from a valid/ready byte stream and writes it to a target programmable device, one byte per chip-select and write-strobe frame. The file opens with a descriptive header that the target must never see. The loader skips that header and begins writing at the sync byte.

A start pulse first holds the target's program line low to clear the device. The loader then scans the source for a 0xFF byte that is directly followed by 0x20, and writes that pair as the first two bytes. From the bytes that follow it picks out the 24-bit length count, which tells it where the bitstream ends. It does not rely on the source to mark the end of the file.

Before every frame the loader waits until the target reports ready. After the last bitstream byte it writes one extra 0xFF, so that the target's three-clock startup always gets enough clocks. It then waits for the done line to rise. The result is reported as success, or as an error with a 2-bit cause code.

Top module: `pcfg_loader`

## Requirements
- R1: A `start` seen while idle, finished or failed drives `cfg_prog_n` low for exactly PROG_CYC cycles, and only after that does the loader read the source. A `start` while `busy` is ignored.
- R2: The loader writes no byte that comes before the marker. The first two writes are 0xFF and then 0x20, and source bytes after the marker are written in order, unchanged.
- R3: A 0xFF followed by any byte other than 0x20 is dropped and the search goes on. A 0x20 that does not follow a 0xFF is also dropped. In a run 0xFF 0xFF 0x20 only the second 0xFF is written.
- R4: The marker's 0xFF may be preceded by at most MAX_HDR header bytes. A source byte that breaks this limit stops the load with `error`=1 and `err_code`=2'b00, and nothing is written.
- R5: The 24-bit length L (in bits) is built from, high to low: the low nibble of file byte 2, file byte 3, file byte 4 and the high nibble of file byte 5, counting the 0xFF as byte 1. The file is max(ceil(L/8), 5) bytes long. The loader accepts no source byte beyond that.
- R6: After the last file byte, the loader writes exactly one 0xFF pad byte.
- R7: In every frame, `cfg_cs_n` goes low one cycle before `cfg_wr_n` goes low. `cfg_wr_n` stays low for exactly WR_LOW cycles, and `cfg_cs_n` rises one cycle after `cfg_wr_n` rises. `cfg_d` does not change while `cfg_cs_n` is low, and `cfg_cs_n` stays high for at least GAP cycles between frames.
- R8: `cfg_cs_n` falls only in the cycle after `tgt_rdy` was sampled high. If `tgt_rdy` stays low for RDY_TMO cycles while a write is waiting, the load stops with `err_code`=2'b01.
- R9: After the pad byte, `done_ok` rises in the cycle after `tgt_done` is sampled high. If `tgt_done` is not seen within DONE_TMO cycles, the load stops with `err_code`=2'b10.
- R10: After reset, and while idle, `busy`, `done_ok` and `error` are low. `busy` is high for the whole load, and `done_ok` and `error` are never high together. A result stays on the outputs until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a load (one-cycle pulse) |
| src_data | input | 8 | Source file byte |
| src_valid | input | 1 | Source byte present |
| src_ready | output | 1 | Loader accepts the source byte |
| tgt_rdy | input | 1 | Target ready (1) / busy (0) flag |
| tgt_done | input | 1 | Target done line, high once startup is complete |
| cfg_prog_n | output | 1 | Program/clear line to target, active low |
| cfg_cs_n | output | 1 | Target chip select, active low |
| cfg_wr_n | output | 1 | Target write strobe, active low |
| cfg_d | output | 8 | Configuration data bus |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Load completed, target reported done |
| error | output | 1 | Load stopped on a fault |
| err_code | output | 2 | Fault cause: 00 no marker, 01 ready timeout, 10 done timeout |

## Verification
Faults in the scanner's lookahead or index show up at the first frame. Either a header byte is written, a 0xFF is written twice, or the header-limit error arrives one byte early or late. The scoreboard catches each of these on the first strobe, by comparing the bytes actually strobed with the bytes expected.

A fault in the length tracker shows up at the end of the file. The pad 0xFF then lands one or more frames early or late, and the source is either still being read or left stalled. Strobe sequencing faults show up within a single frame, as a wrong strobe width, a missing chip-select lead or hold, or a frame started while the target model reports busy.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

   localparam int         LEN_BITS  = 24;     // width of the bit-length field
   localparam int         MIN_FRAME = 5;      // bytes needed to hold the length field
   localparam logic [7:0] SYNC_BYTE = 8'hFF;  // dummy byte that opens the bitstream
   localparam logic [7:0] PRE_BYTE  = 8'h20;  // preamble nibble + top length nibble
   localparam logic [7:0] PAD_BYTE  = 8'hFF;  // trailing clock-supply byte

   typedef enum logic [1:0] {
      ERR_NOHDR = 2'b00,
      ERR_RDY   = 2'b01,
      ERR_DONE  = 2'b10,
      ERR_RSVD  = 2'b11
   } err_e;

   typedef enum logic [3:0] {
      LD_IDLE, LD_PROG, LD_SCAN, LD_SYNC, LD_PRE,
      LD_BODY, LD_PAD, LD_DWAIT, LD_OK, LD_FAIL
   } ld_state_e;

   typedef enum logic [2:0] {
      WP_IDLE, WP_WAIT, WP_SETUP, WP_STRB, WP_HOLD, WP_GAP
   } wp_state_e;

endpackage

// File: rtl/pcfg_hdr_scan.sv
module pcfg_hdr_scan
   import pcfg_pkg::*;
#(
   parameter int MAX_HDR = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       take,
   input  logic [7:0] din,
   output logic       found,
   output logic       abort
);
   localparam int                IDX_W = $clog2(MAX_HDR + 2);
   localparam logic [IDX_W-1:0]  LIMIT = IDX_W'(MAX_HDR);

   generate
      if (MAX_HDR < 72) begin : g_bad_limit
         $error("pcfg_hdr_scan: MAX_HDR must cover a header of at least 72 bytes");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;   // stream index of the byte now offered
   logic             ff_q;    // previous accepted byte was a sync candidate
   logic             is_sync, is_pre, over;

   assign is_sync = (din == SYNC_BYTE);
   assign is_pre  = (din == PRE_BYTE);
   assign found   = take && ff_q && is_pre;
   // a sync byte may sit at index LIMIT at most; anything later breaks the limit
   assign over    = (idx_q > LIMIT) || ((idx_q == LIMIT) && !is_sync);
   assign abort   = take && !found && over;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         ff_q  <= 1'b0;
      end else if (clr) begin
         idx_q <= '0;
         ff_q  <= 1'b0;
      end else if (take) begin
         ff_q <= is_sync;
         if (idx_q <= LIMIT) idx_q <= idx_q + 1'b1;
      end
   end

   AST_FOUND_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> $past(take) && $past(din) == SYNC_BYTE) else $error("marker without sync"); // R3

endmodule

// File: rtl/pcfg_len_count.sv
module pcfg_len_count
   import pcfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       take,
   input  logic [7:0] din,
   output logic       last
);
   localparam int NB_W = LEN_BITS - 3 + 1;   // byte index / byte count width

   logic [NB_W-1:0]     idx_q, idx_n;        // file index of the last written byte
   logic [7:0]          b3_q, b4_q;
   logic [3:0]          nib_q, nib;
   logic [LEN_BITS-1:0] len_now;
   logic [LEN_BITS:0]   rnd;
   logic [NB_W-1:0]     nbytes, last_idx;

   assign idx_n    = idx_q + 1'b1;
   assign nib      = (idx_n == NB_W'(MIN_FRAME)) ? din[7:4] : nib_q;
   // top nibble comes from the preamble byte, whose low nibble is always zero
   assign len_now  = {4'h0, b3_q, b4_q, nib};
   assign rnd      = {1'b0, len_now} + (LEN_BITS+1)'(7);
   assign nbytes   = rnd[LEN_BITS:3];
   assign last_idx = (nbytes < NB_W'(MIN_FRAME)) ? NB_W'(MIN_FRAME) : nbytes;
   assign last     = take && (idx_n >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         b3_q  <= '0;
         b4_q  <= '0;
         nib_q <= '0;
      end else if (clr) begin
         idx_q <= NB_W'(2);
         b3_q  <= '0;
         b4_q  <= '0;
         nib_q <= '0;
      end else if (take) begin
         idx_q <= idx_n;
         if (idx_n == NB_W'(3)) b3_q <= din;
         if (idx_n == NB_W'(4)) b4_q <= din;
         if (idx_n == NB_W'(MIN_FRAME)) nib_q <= din[7:4];
      end
   end

   AST_LAST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> idx_q >= NB_W'(MIN_FRAME - 1)) else $error("file ended inside length field"); // R5

endmodule

// File: rtl/pcfg_wr_port.sv
module pcfg_wr_port
   import pcfg_pkg::*;
#(
   parameter int WR_LOW  = 2,
   parameter int GAP     = 1,
   parameter int RDY_TMO = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic [7:0] din,
   input  logic       rdy,
   output logic       idle,
   output logic       tmo,
   output logic       cs_n,
   output logic       wr_n,
   output logic [7:0] dout
);
   localparam int MAX_A = (WR_LOW > GAP) ? WR_LOW : GAP;
   localparam int MAX_C = (MAX_A > RDY_TMO) ? MAX_A : RDY_TMO;
   localparam int CW    = $clog2(MAX_C + 1);

   generate
      if (WR_LOW < 1 || GAP < 0 || RDY_TMO < 1) begin : g_bad_cfg
         $error("pcfg_wr_port: WR_LOW and RDY_TMO must be >= 1, GAP >= 0");
      end
   endgenerate

   wp_state_e      st_q, hold_nxt;
   logic [CW-1:0]  cnt_q;
   logic [7:0]     d_q;
   logic           strb_last, gap_last;

   generate
      if (WR_LOW == 1) begin : g_strb_one
         assign strb_last = 1'b1;
      end else begin : g_strb_cnt
         assign strb_last = (cnt_q == CW'(WR_LOW - 1));
      end
      if (GAP == 0) begin : g_no_gap
         assign hold_nxt = WP_IDLE;
         assign gap_last = 1'b1;
      end else begin : g_gap
         assign hold_nxt = WP_GAP;
         assign gap_last = (cnt_q == CW'(GAP - 1));
      end
   endgenerate

   assign idle = (st_q == WP_IDLE);
   assign tmo  = (st_q == WP_WAIT) && !rdy && (cnt_q == CW'(RDY_TMO - 1));
   assign cs_n = !((st_q == WP_SETUP) || (st_q == WP_STRB) || (st_q == WP_HOLD));
   assign wr_n = (st_q != WP_STRB);
   assign dout = d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= WP_IDLE;
         cnt_q <= '0;
         d_q   <= '0;
      end else begin
         case (st_q)
            WP_IDLE: if (req) begin
               st_q  <= WP_WAIT;
               cnt_q <= '0;
               d_q   <= din;
            end
            WP_WAIT: begin
               if (rdy) st_q <= WP_SETUP;
               else if (tmo) st_q <= WP_IDLE;
               else cnt_q <= cnt_q + 1'b1;
            end
            WP_SETUP: begin
               st_q  <= WP_STRB;
               cnt_q <= '0;
            end
            WP_STRB: begin
               if (strb_last) st_q <= WP_HOLD;
               else cnt_q <= cnt_q + 1'b1;
            end
            WP_HOLD: begin
               st_q  <= hold_nxt;
               cnt_q <= '0;
            end
            WP_GAP: begin
               if (gap_last) st_q <= WP_IDLE;
               else cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= WP_IDLE;
         endcase
      end
   end

   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !cs_n) else $error("strobe outside select"); // R7
   AST_CS_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> $past(!cs_n && wr_n)) else $error("select did not lead strobe"); // R7
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(dout)) else $error("data moved in frame"); // R7
   AST_RDY_BEFORE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(rdy)) else $error("frame opened while target busy"); // R8

endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
   import pcfg_pkg::*;
#(
   parameter int MAX_HDR  = 256,
   parameter int PROG_CYC = 16,
   parameter int WR_LOW   = 2,
   parameter int GAP      = 1,
   parameter int RDY_TMO  = 1024,
   parameter int DONE_TMO = 65536
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] src_data,
   input  logic       src_valid,
   output logic       src_ready,
   input  logic       tgt_rdy,
   input  logic       tgt_done,
   output logic       cfg_prog_n,
   output logic       cfg_cs_n,
   output logic       cfg_wr_n,
   output logic [7:0] cfg_d,
   output logic       busy,
   output logic       done_ok,
   output logic       error,
   output logic [1:0] err_code
);
   localparam int CNT_MAX = (PROG_CYC > DONE_TMO) ? PROG_CYC : DONE_TMO;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (PROG_CYC < 1 || DONE_TMO < 1) begin : g_bad_cfg
         $error("pcfg_loader: PROG_CYC and DONE_TMO must be >= 1");
      end
   endgenerate

   ld_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   err_e             err_q;

   logic       wp_req, wp_idle, wp_tmo;
   logic [7:0] wp_din;
   logic       take_scan, take_body, hdr_found, hdr_abort, body_last, clr;
   logic       settled;

   assign settled    = (st_q == LD_IDLE) || (st_q == LD_OK) || (st_q == LD_FAIL);
   assign clr        = (st_q == LD_PROG);
   assign take_scan  = (st_q == LD_SCAN) && src_valid;
   assign take_body  = (st_q == LD_BODY) && src_valid && wp_idle;
   assign src_ready  = (st_q == LD_SCAN) || ((st_q == LD_BODY) && wp_idle);
   assign cfg_prog_n = (st_q != LD_PROG);
   assign busy       = !settled;
   assign done_ok    = (st_q == LD_OK);
   assign error      = (st_q == LD_FAIL);
   assign err_code   = err_q;

   always_comb begin
      wp_req = 1'b0;
      wp_din = src_data;
      case (st_q)
         LD_SYNC: begin wp_req = wp_idle;   wp_din = SYNC_BYTE; end
         LD_PRE:  begin wp_req = wp_idle;   wp_din = PRE_BYTE;  end
         LD_BODY: begin wp_req = take_body; wp_din = src_data;  end
         LD_PAD:  begin wp_req = wp_idle;   wp_din = PAD_BYTE;  end
         default: ;
      endcase
   end

   pcfg_hdr_scan #(.MAX_HDR(MAX_HDR)) i_scan (
      .clk(clk), .rst_n(rst_n), .clr(clr), .take(take_scan), .din(src_data),
      .found(hdr_found), .abort(hdr_abort)
   );

   pcfg_len_count i_len (
      .clk(clk), .rst_n(rst_n), .clr(clr), .take(take_body), .din(src_data),
      .last(body_last)
   );

   pcfg_wr_port #(.WR_LOW(WR_LOW), .GAP(GAP), .RDY_TMO(RDY_TMO)) i_port (
      .clk(clk), .rst_n(rst_n), .req(wp_req), .din(wp_din), .rdy(tgt_rdy),
      .idle(wp_idle), .tmo(wp_tmo), .cs_n(cfg_cs_n), .wr_n(cfg_wr_n), .dout(cfg_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LD_IDLE;
         cnt_q <= '0;
         err_q <= ERR_NOHDR;
      end else begin
         case (st_q)
            LD_IDLE, LD_OK, LD_FAIL: if (start) begin
               st_q  <= LD_PROG;
               cnt_q <= '0;
            end
            LD_PROG: begin
               if (cnt_q == CNT_W'(PROG_CYC - 1)) st_q <= LD_SCAN;
               else cnt_q <= cnt_q + 1'b1;
            end
            LD_SCAN: begin
               if (hdr_found) st_q <= LD_SYNC;
               else if (hdr_abort) begin
                  st_q  <= LD_FAIL;
                  err_q <= ERR_NOHDR;
               end
            end
            LD_SYNC, LD_PRE, LD_BODY, LD_PAD: begin
               if (wp_tmo) begin
                  st_q  <= LD_FAIL;
                  err_q <= ERR_RDY;
               end else begin
                  case (st_q)
                     LD_SYNC: if (wp_idle) st_q <= LD_PRE;
                     LD_PRE:  if (wp_idle) st_q <= LD_BODY;
                     LD_BODY: if (take_body && body_last) st_q <= LD_PAD;
                     default: if (wp_idle) begin
                        st_q  <= LD_DWAIT;
                        cnt_q <= '0;
                     end
                  endcase
               end
            end
            LD_DWAIT: begin
               if (wp_tmo) begin
                  st_q  <= LD_FAIL;
                  err_q <= ERR_RDY;
               end else if (wp_idle) begin
                  if (tgt_done) st_q <= LD_OK;
                  else if (cnt_q == CNT_W'(DONE_TMO - 1)) begin
                     st_q  <= LD_FAIL;
                     err_q <= ERR_DONE;
                  end else cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= LD_IDLE;
         endcase
      end
   end

   AST_SRC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> busy) else $error("source read while not loading"); // R10
   AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_ok && error)) else $error("success and fault together"); // R10
   AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_prog_n |-> (cfg_cs_n && !src_ready)) else $error("activity during clear"); // R1
   AST_DONE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_ok) |-> $past(tgt_done)) else $error("success without done pin"); // R9

endmodule

// File: tb/test_pcfg_loader.sv
module test_pcfg_loader;
   localparam int MAX_HDR  = 96;
   localparam int PROG_CYC = 5;
   localparam int WR_LOW   = 2;
   localparam int GAP      = 1;
   localparam int RDY_TMO  = 64;
   localparam int DONE_TMO = 200;

   logic       clk = 1'b0;
   logic       rst_n, start, src_valid, tgt_rdy, tgt_done;
   logic [7:0] src_data;
   logic       src_ready, cfg_prog_n, cfg_cs_n, cfg_wr_n, busy, done_ok, error;
   logic [7:0] cfg_d;
   logic [1:0] err_code;

   always #5 clk = ~clk;

   pcfg_loader #(.MAX_HDR(MAX_HDR), .PROG_CYC(PROG_CYC), .WR_LOW(WR_LOW), .GAP(GAP),
                 .RDY_TMO(RDY_TMO), .DONE_TMO(DONE_TMO)) i_pcfg_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data), .src_valid(src_valid),
      .src_ready(src_ready), .tgt_rdy(tgt_rdy), .tgt_done(tgt_done), .cfg_prog_n(cfg_prog_n),
      .cfg_cs_n(cfg_cs_n), .cfg_wr_n(cfg_wr_n), .cfg_d(cfg_d), .busy(busy), .done_ok(done_ok),
      .error(error), .err_code(err_code)
   );

   int         total = 0, bad = 0, cyc = 0;
   logic [7:0] exp_q[$];

   // target model and monitor state
   bit  rdy_stuck = 0, no_done = 0;
   int  busy_left = 0, strobes = 0, done_at = 0, done_dly = 0;
   int  wlow = 0, hi_cnt = 0, plow = 0, prog_pulses = 0, frames = 0;
   logic prev_cs = 1'b1, prev_wr = 1'b1, prev_prog = 1'b1;
   logic [7:0] e_byte;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         // monitor: frame shape, ready rule and scoreboard
         if (prev_cs && !cfg_cs_n) begin
            chk(tgt_rdy == 1'b1, "R8", "frame opened while busy", 0, 1);
            if (frames > 0) chk(hi_cnt >= GAP, "R7", "gap between frames", hi_cnt, GAP);
            frames++;
         end
         if (cfg_cs_n) hi_cnt++; else hi_cnt = 0;
         if (prev_wr && !cfg_wr_n) begin
            chk(prev_cs == 1'b0, "R7", "select lead before strobe", prev_cs, 0);
            if (exp_q.size() == 0) chk(0, "R2", "unexpected write", cfg_d, 0);
            else begin
               e_byte = exp_q.pop_front();
               chk(cfg_d == e_byte, "R2", "written byte", cfg_d, e_byte);
            end
         end
         if (!cfg_wr_n) wlow++;
         if (!prev_wr && cfg_wr_n) begin
            chk(wlow == WR_LOW, "R7", "strobe width", wlow, WR_LOW);
            chk(cfg_cs_n == 1'b0, "R7", "select hold after strobe", cfg_cs_n, 0);
            wlow = 0;
         end
         if (!cfg_prog_n) plow++;
         if (!prev_prog && cfg_prog_n) begin
            chk(plow == PROG_CYC, "R1", "clear pulse width", plow, PROG_CYC);
            prog_pulses++;
            plow = 0;
         end
         // target model update
         if (!cfg_prog_n) begin
            strobes = 0; tgt_done = 1'b0; done_dly = 0; busy_left = 0;
         end else begin
            if (!prev_wr && cfg_wr_n) begin
               strobes++;
               busy_left = 3;
            end else if (busy_left > 0) busy_left--;
            if (strobes == done_at && !no_done && !tgt_done) begin
               done_dly++;
               if (done_dly == 3) tgt_done = 1'b1;
            end
         end
         tgt_rdy   = !rdy_stuck && (busy_left == 0);
         prev_cs   = cfg_cs_n;
         prev_wr   = cfg_wr_n;
         prev_prog = cfg_prog_n;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [7:0] hdr_byte(input int i);
      if (i == 10) return 8'hFF;      // lone sync candidate
      if (i == 11) return 8'h21;
      if (i == 12) return 8'h20;      // preamble value not after a sync
      return 8'((i * 37 + 5) & 8'h7F);
   endfunction

   function automatic logic [7:0] file_byte(input int k, input logic [23:0] len);
      case (k)
         1: return 8'hFF;
         2: return {4'h2, len[23:20]};
         3: return len[19:12];
         4: return len[11:4];
         5: return {len[3:0], 4'hA};
         default: return 8'((k * 29 + 1) & 8'hFF);
      endcase
   endfunction

   task automatic push_byte(input logic [7:0] b);
      @(negedge clk);
      src_valid = 1'b1;
      src_data  = b;
      while (!src_ready) @(negedge clk);
      @(posedge clk);
      #1 src_valid = 1'b0;
   endtask

   task automatic start_load();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_end();
      int n = 0;
      while (!(done_ok || error) && n < 5000) begin
         @(negedge clk); n++;
      end
      chk(n < 5000, "R10", "load never settled", n, 5000);
   endtask

   // header of hdr_n bytes, file of max(units,5) bytes with L = units*8
   task automatic send_file(input int hdr_n, input bit dbl, input int units,
                            input bit mid_start);
      logic [23:0] len = 24'(units * 8);
      int tcount = (units < 5) ? 5 : units;
      for (int k = 1; k <= tcount; k++) exp_q.push_back(file_byte(k, len));
      exp_q.push_back(8'hFF);
      done_at = tcount + 1;
      start_load();
      chk(busy == 1'b1, "R10", "busy during load", busy, 1);
      for (int i = 0; i < hdr_n; i++)
         push_byte((dbl && i == hdr_n - 1) ? 8'hFF : hdr_byte(i));
      for (int k = 1; k <= tcount; k++) begin
         push_byte(file_byte(k, len));
         if (mid_start && k == 10) begin
            start_load();
            for (int j = 0; j < 4; j++) begin
               @(negedge clk);
               chk(cfg_prog_n == 1'b1, "R1", "start ignored while busy", cfg_prog_n, 1);
            end
         end
      end
      wait_end();
      chk(done_ok == 1'b1 && error == 1'b0, "R9", "done_ok after done pin", done_ok, 1);
      chk(exp_q.size() == 0, "R2", "bytes left unwritten", exp_q.size(), 0);
      chk(strobes == tcount + 1, "R6", "frames incl. one pad", strobes, tcount + 1);
      chk(src_ready == 1'b0, "R5", "no read past file end", src_ready, 0);
      exp_q.delete();
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; src_valid = 1'b0; src_data = 8'h00;
      tgt_rdy = 1'b1; tgt_done = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy == 0 && done_ok == 0 && error == 0, "R10", "reset status",
          {busy, done_ok, error}, 0);
      chk(cfg_cs_n && cfg_wr_n && cfg_prog_n && !src_ready, "R10", "reset pins",
          {cfg_cs_n, cfg_wr_n, cfg_prog_n, src_ready}, 4'b1110);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3: 70-byte header with a lone sync, 12-byte file
      send_file(70, 1'b0, 12, 1'b0);
      // R3 R1: header ending in sync so 0xFF 0xFF 0x20, start pulsed mid-file
      send_file(40, 1'b1, 40, 1'b1);
      // R4 R5: header of exactly MAX_HDR bytes, length 16 bits -> minimum 5-byte file
      send_file(MAX_HDR, 1'b0, 2, 1'b0);

      // R4: one header byte too many
      start_load();
      for (int i = 0; i <= MAX_HDR; i++) push_byte(hdr_byte(i));
      wait_end();
      chk(error == 1'b1 && err_code == 2'b00, "R4", "header limit fault",
          {error, err_code}, 3'b100);
      chk(frames == 0 || exp_q.size() == 0, "R4", "nothing written", exp_q.size(), 0);

      // R8: target never ready
      rdy_stuck = 1'b1;
      @(negedge clk);
      start_load();
      for (int i = 0; i < 8; i++) push_byte(hdr_byte(i));
      push_byte(8'hFF);
      push_byte(8'h20);
      wait_end();
      chk(error == 1'b1 && err_code == 2'b01, "R8", "ready timeout code",
          {error, err_code}, 3'b101);
      chk(strobes == 0, "R8", "no strobe while busy", strobes, 0);
      rdy_stuck = 1'b0;

      // R9: done never rises
      no_done = 1'b1;
      begin
         logic [23:0] len = 24'd48;
         for (int k = 1; k <= 6; k++) exp_q.push_back(file_byte(k, len));
         exp_q.push_back(8'hFF);
         start_load();
         for (int i = 0; i < 20; i++) push_byte(hdr_byte(i));
         for (int k = 1; k <= 6; k++) push_byte(file_byte(k, len));
         wait_end();
         chk(error == 1'b1 && err_code == 2'b10, "R9", "done timeout code",
             {error, err_code}, 3'b110);
         chk(exp_q.size() == 0, "R6", "file and pad written", exp_q.size(), 0);
         exp_q.delete();
      end
      no_done = 1'b0;

      // R10: restart after a fault clears status and completes
      send_file(64, 1'b0, 7, 1'b0);
      chk(err_code == 2'b10 && error == 1'b0, "R10", "error flag cleared on restart",
          error, 0);

      chk(prog_pulses == 7, "R1", "accepted starts", prog_pulses, 7);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule